// File: doc/BRIEF.md
# Cascadable Serial-to-Parallel Segment Loader

This block turns a slow serial segment stream into a 38-bit parallel word for a display driver. A data line is clocked into a shift register on the falling edge of an active-low serial clock while chip select is low. The most recent bit enters the first stage. An active-high load strobe opens a level-sensitive latch, and while the strobe is high the parallel word follows the register contents.

Three serial taps, taken from stages 30, 32 and 38, are re-registered on the rising serial clock edge. The next device in a chain can sample them on its own falling edge. All serial pins are asynchronous to the system clock. Each pin passes through a two-flop synchronizer, and edges are found at the system clock rate. The serial clock period must therefore span at least eight system clocks.

Top module: `seg_shift_loader`

## Requirements
- R1: The shift register has 38 stages. Stage 1 takes the newest bit, and stage k appears on `seg_q[k-1]`. After 38 shifts and a load, `seg_q[37]` holds the first bit that was sent.
- R2: A shift happens only on a high-to-low transition of `ser_clk_n` while `cs_n` is low. Transitions that occur while `cs_n` is high leave the register unchanged.
- R3: While `load` is high and `cs_n` is low, `seg_q` follows the shift register, including any shifts made during the strobe.
- R4: `seg_q` holds its value while `load` is low. A load pulse given while `cs_n` is high leaves `seg_q` unchanged.
- R5: `tap_30`, `tap_32` and `tap_38` show stages 30, 32 and 38. They update only on a low-to-high transition of `ser_clk_n`, so a falling edge alone leaves them unchanged.
- R6: An active-low `rst_n` clears the register, `seg_q` and all three taps to zero. This also holds when reset is applied in the middle of operation.
- R7: The block operates correctly with a serial clock half-period of four system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_dat | input | 1 | Serial segment data |
| ser_clk_n | input | 1 | Serial clock; shifts on its falling edge |
| cs_n | input | 1 | Active-low chip select |
| load | input | 1 | Active-high latch strobe |
| seg_q | output | 38 | Latched segment word, bit k-1 = stage k |
| tap_30 | output | 1 | Cascade tap from stage 30 |
| tap_32 | output | 1 | Cascade tap from stage 32 |
| tap_38 | output | 1 | Cascade tap from stage 38 |

## Verification
The hardest case to reach from the ports is the gap between a falling serial edge and the rising edge that follows it. During that gap the register has already shifted but the taps must not have moved yet. The bench holds the serial clock low for four system clocks, checks the taps there, then releases the clock and checks them again. A second hard case is a shift made while the load strobe is held high, which shows that the latch is transparent and not edge-triggered. A third is a full word shifted while chip select is high, followed by a proper load, which shows that the register never moved.

// File: rtl/seg_shift_loader.sv
module seg_shift_loader #(
  parameter int STAGES = 38,
  parameter int TAP_A  = 30,
  parameter int TAP_B  = 32,
  parameter int SYNC   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_dat,
  input  logic              ser_clk_n,
  input  logic              cs_n,
  input  logic              load,
  output logic [STAGES-1:0] seg_q,
  output logic              tap_30,
  output logic              tap_32,
  output logic              tap_38
);

  logic [SYNC-1:0]   ck_sy, dt_sy, cs_sy, ld_sy;
  logic              ck_prev;
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_sy <= '0;
      dt_sy <= '0;
      cs_sy <= '0;
      ld_sy <= '0;
    end else begin
      ck_sy <= {ck_sy[SYNC-2:0], ser_clk_n};
      dt_sy <= {dt_sy[SYNC-2:0], ser_dat};
      cs_sy <= {cs_sy[SYNC-2:0], cs_n};
      ld_sy <= {ld_sy[SYNC-2:0], load};
    end
  end

  wire ck_s   = ck_sy[SYNC-1];
  wire dt_s   = dt_sy[SYNC-1];
  wire sel_s  = ~cs_sy[SYNC-1];
  wire ld_s   = ld_sy[SYNC-1];
  wire fall   = ck_prev & ~ck_s;
  wire rise   = ~ck_prev & ck_s;
  wire do_sh  = fall & sel_s;
  wire do_ld  = ld_s & sel_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_prev <= 1'b0;
      sr_q    <= '0;
      seg_q   <= '0;
      tap_30  <= 1'b0;
      tap_32  <= 1'b0;
      tap_38  <= 1'b0;
    end else begin
      ck_prev <= ck_s;
      if (do_sh) sr_q <= {sr_q[STAGES-2:0], dt_s};
      if (do_ld) seg_q <= sr_q;
      if (rise) begin
        tap_30 <= sr_q[TAP_A-1];
        tap_32 <= sr_q[TAP_B-1];
        tap_38 <= sr_q[STAGES-1];
      end
    end
  end

  assert_shift_R1: assert property (@(posedge clk) disable iff (!rst_n)
    do_sh |=> (sr_q[0] == $past(dt_s)) && (sr_q[STAGES-1:1] == $past(sr_q[STAGES-2:0])));

  assert_no_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !sel_s |=> $stable(sr_q));

  assert_follow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    do_ld |=> seg_q == $past(sr_q));

  assert_latch_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !do_ld |=> $stable(seg_q));

  assert_tap_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rise |=> $stable({tap_30, tap_32, tap_38}));

endmodule

// File: tb/seg_shift_loader_tb.sv
module seg_shift_loader_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_dat = 1'b0;
  logic        ser_clk_n = 1'b1;
  logic        cs_n = 1'b1;
  logic        load = 1'b0;
  logic [37:0] seg_q;
  logic        tap_30, tap_32, tap_38;

  int nvec = 0;
  int nbad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  seg_shift_loader u_dut (
    .clk(clk), .rst_n(rst_n), .ser_dat(ser_dat), .ser_clk_n(ser_clk_n),
    .cs_n(cs_n), .load(load), .seg_q(seg_q),
    .tap_30(tap_30), .tap_32(tap_32), .tap_38(tap_38)
  );

  localparam int NV = 7;
  localparam logic [37:0] VEC [NV] = '{
    38'h3FFFFFFFFF, 38'h1555555555, 38'h2AAAAAAAAA, 38'h0000000001,
    38'h2000000000, 38'h0F0F00F0F3, 38'h123456789A
  };

  task automatic wait_n(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, logic [37:0] act, logic [37:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic ser_bit(logic d);
    ser_dat = d;
    ser_clk_n = 1'b0;
    wait_n(4);
    ser_clk_n = 1'b1;
    wait_n(4);
  endtask

  task automatic shift_word(logic [37:0] w);
    for (int i = 37; i >= 0; i--) ser_bit(w[i]);
  endtask

  task automatic pulse_load();
    load = 1'b1;
    wait_n(4);
    load = 1'b0;
    wait_n(4);
  endtask

  task automatic chk_taps(string tag, logic [37:0] w);
    chk({tag, " tap_30"}, {37'b0, tap_30}, {37'b0, w[29]});
    chk({tag, " tap_32"}, {37'b0, tap_32}, {37'b0, w[31]});
    chk({tag, " tap_38"}, {37'b0, tap_38}, {37'b0, w[37]});
  endtask

  initial begin
    logic [37:0] p, q;
    wait_n(3);
    chk("R6 reset seg", seg_q, '0);
    chk_taps("R6 reset", '0);
    rst_n = 1'b1;
    wait_n(4);
    cs_n = 1'b0;
    wait_n(4);

    // R1 R5 R7: table of words, 8-sysclk serial period
    for (int v = 0; v < NV; v++) begin
      shift_word(VEC[v]);
      pulse_load();
      chk("R1 R7 word", seg_q, VEC[v]);
      chk_taps("R5 taps", VEC[v]);
    end
    p = VEC[NV-1];

    // R2: clocking with cs_n high does not shift; R4: load with cs_n high ignored
    cs_n = 1'b1;
    wait_n(4);
    shift_word(~p);
    chk_taps("R2 taps cs high", p);
    pulse_load();
    chk("R4 load cs high", seg_q, p);
    cs_n = 1'b0;
    wait_n(4);
    pulse_load();
    chk("R2 reg unchanged", seg_q, p);

    // R4: no load -> hold
    q = 38'h1E5A3C96F0;
    shift_word(q);
    chk("R4 hold no load", seg_q, p);

    // R5: falling edge alone leaves taps
    ser_dat = 1'b1;
    ser_clk_n = 1'b0;
    wait_n(4);
    chk_taps("R5 after fall", q);
    ser_clk_n = 1'b1;
    wait_n(4);
    chk_taps("R5 after rise", {q[36:0], 1'b1});

    // R3: transparent while load high
    load = 1'b1;
    wait_n(4);
    chk("R3 open", seg_q, {q[36:0], 1'b1});
    ser_bit(1'b0);
    chk("R3 follows shift", seg_q, {q[35:0], 2'b10});
    load = 1'b0;
    wait_n(4);
    ser_bit(1'b1);
    chk("R4 closed", seg_q, {q[35:0], 2'b10});

    // R6: reset mid-operation
    rst_n = 1'b0;
    wait_n(2);
    chk("R6 mid reset seg", seg_q, '0);
    chk_taps("R6 mid reset", '0);
    rst_n = 1'b1;
    wait_n(4);
    pulse_load();
    chk("R6 reg cleared", seg_q, '0);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        nvec++;
        nbad++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

endmodule